// File: doc/BRIEF.md
# Startup Offset Calibration Sequencer

This block runs one timed calibration pass each time a software hold bit is released. While the pass runs, it reads one converter sample per clock and moves a signed correction word by one LSB toward the value that would bring the sample to its zero-offset code. The word stops at the edges of its signed range. The word always drives the offset DAC after a black-clamp level has been added to it. That level is chosen by a small code: 14 LSB plus 2 LSB per code step, so codes 0, 9 and 31 give 14, 32 and 76 LSB.

No start command exists. Dropping the hold bit starts the pass on the next clock. The pass lasts a parameterized number of conversion-clock cycles, 40000 by default, which is 2 ms at 20 MHz. A busy flag marks the pass, and a single-cycle done pulse marks its end. Raising the hold bit again at any point aborts the pass and clears both the cycle count and the correction word. The next release starts a full pass from the beginning.

Top module: `ocal_sequencer`

## Requirements
- R1: While `rst_n` is low, `busy` and `done` are 0 and the correction word is 0, so `dac_code` equals the clamp level alone.
- R2: On the first clock edge at which `reset_mode` is sampled low while idle, a pass starts, and `busy` is 1 right after that edge. No other input is needed.
- R3: `busy` stays high for exactly CAL_CYCLES consecutive clock cycles per completed pass.
- R4: `done` is a one-cycle pulse in the first cycle after `busy` falls at the end of a completed pass. It does not repeat until a new pass completes.
- R5: At each clock edge sampled while `busy` is 1 and `reset_mode` is 0, the correction word changes by one LSB. It goes down by 1 if `sample` is above ZERO_LEVEL (default 512), up by 1 if `sample` is below ZERO_LEVEL, and holds if `sample` equals ZERO_LEVEL.
- R6: The correction word saturates at -2^(CANCEL_W-1) and at 2^(CANCEL_W-1)-1 and never wraps.
- R7: `dac_code` is the two's-complement sum of the correction word and 14 + 2 × `clamp_code`, so codes 0, 9 and 31 add 14, 32 and 76. It follows `clamp_code` in the same cycle.
- R8: A clock edge with `reset_mode` high aborts any pass. After that edge `busy` and `done` are 0, the correction word is 0 and the cycle count is cleared, so the next release gives a full CAL_CYCLES window.
- R9: Outside a pass, whether after completion or while `reset_mode` is high, `sample` has no effect on `dac_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous chip reset, active low |
| reset_mode | input | 1 | Software hold bit; high holds and aborts, falling starts a pass |
| sample | input | SAMPLE_W (10) | Converter output sample, unsigned |
| clamp_code | input | CODE_W (5) | Black-clamp level select |
| dac_code | output | DAC_W (9) | Signed offset DAC code: correction word plus clamp level |
| busy | output | 1 | High during the calibration window |
| done | output | 1 | One-cycle pulse at the end of a completed window |

## Verification
The hold bit can rise in the same cycle as the window's last step. In that cycle, abort and completion compete for the same edge. The bench provokes this by releasing the hold, waiting CAL_CYCLES-1 stepping edges and then raising `reset_mode` just before the edge that would end the window. The result is judged correct only if no `done` pulse ever appears, `busy` drops and `dac_code` falls back to the bare clamp level. A second collision comes from changing `clamp_code` in the same cycles in which the correction word steps, and every cycle of that sweep is checked against the sum computed in the bench.

// File: rtl/ocal_pkg.sv
package ocal_pkg;

   typedef enum logic [1:0] {
      ST_HOLD = 2'd0,
      ST_RUN  = 2'd1,
      ST_END  = 2'd2
   } ocal_state_e;

   function automatic int ocal_max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic bit ocal_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ocal_window_timer.sv
module ocal_window_timer
   import ocal_pkg::*;
#(
   parameter int unsigned CAL_CYCLES = 40000,
   parameter bit          COUNT_DOWN = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic run,
   output logic finish
);

   localparam int unsigned CNT_W = $clog2(CAL_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST_UP = CNT_W'(CAL_CYCLES - 1);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   ocal_state_e      state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_start;
   logic [CNT_W-1:0] cnt_next;
   logic             last_w;
   logic             fin_q;

   generate
      if (COUNT_DOWN) begin : g_down
         assign cnt_start = LAST_UP;
         assign cnt_next  = cnt_q - ONE;
         assign last_w    = (cnt_q == '0);
      end else begin : g_up
         assign cnt_start = '0;
         assign cnt_next  = cnt_q + ONE;
         assign last_w    = (cnt_q == LAST_UP);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HOLD;
         cnt_q   <= '0;
         fin_q   <= 1'b0;
      end else if (hold) begin
         state_q <= ST_HOLD;
         cnt_q   <= '0;
         fin_q   <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         case (state_q)
            ST_HOLD: begin
               state_q <= ST_RUN;
               cnt_q   <= cnt_start;
            end
            ST_RUN: begin
               if (last_w) begin
                  state_q <= ST_END;
                  fin_q   <= 1'b1;
               end else begin
                  cnt_q <= cnt_next;
               end
            end
            ST_END: begin
               state_q <= ST_END;
            end
            default: begin
               state_q <= ST_HOLD;
               cnt_q   <= '0;
            end
         endcase
      end
   end

   assign run    = (state_q == ST_RUN);
   assign finish = fin_q;

endmodule

// File: rtl/ocal_cancel_accum.sv
module ocal_cancel_accum #(
   parameter int SAMPLE_W   = 10,
   parameter int CANCEL_W   = 8,
   parameter int ZERO_LEVEL = 512
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       step_en,
   input  logic [SAMPLE_W-1:0]        sample,
   output logic signed [CANCEL_W-1:0] cancel
);

   localparam logic [SAMPLE_W-1:0]        ZERO  = SAMPLE_W'(ZERO_LEVEL);
   localparam logic signed [CANCEL_W-1:0] C_MAX = {1'b0, {(CANCEL_W-1){1'b1}}};
   localparam logic signed [CANCEL_W-1:0] C_MIN = {1'b1, {(CANCEL_W-1){1'b0}}};
   localparam logic signed [CANCEL_W-1:0] C_ONE = {{(CANCEL_W-1){1'b0}}, 1'b1};

   logic signed [CANCEL_W-1:0] word_q;
   logic signed [CANCEL_W-1:0] word_nxt;
   logic                       above;
   logic                       below;
   logic                       at_max;
   logic                       at_min;

   assign above  = (sample > ZERO);
   assign below  = (sample < ZERO);
   assign at_max = (word_q == C_MAX);
   assign at_min = (word_q == C_MIN);

   always_comb begin
      word_nxt = word_q;
      if (above && !at_min) begin
         word_nxt = word_q - C_ONE;
      end else if (below && !at_max) begin
         word_nxt = word_q + C_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (clear) begin
         word_q <= '0;
      end else if (step_en) begin
         word_q <= word_nxt;
      end
   end

   assign cancel = word_q;

endmodule

// File: rtl/ocal_clamp_adder.sv
module ocal_clamp_adder
   import ocal_pkg::*;
#(
   parameter int CODE_W   = 5,
   parameter int LVL_BASE = 14,
   parameter int LVL_STEP = 2,
   parameter int LVL_W    = 7,
   parameter int CANCEL_W = 8,
   parameter int DAC_W    = 9
) (
   input  logic signed [CANCEL_W-1:0] cancel,
   input  logic [CODE_W-1:0]          code,
   output logic signed [DAC_W-1:0]    dac
);

   logic [LVL_W-1:0]        level;
   logic signed [DAC_W-1:0] cancel_ext;
   logic signed [DAC_W-1:0] level_ext;

   generate
      if (ocal_is_pow2(LVL_STEP)) begin : g_shift
         localparam int SH = $clog2(LVL_STEP);
         assign level = LVL_W'(LVL_BASE) + (LVL_W'(code) << SH);
      end else begin : g_mult
         assign level = LVL_W'(LVL_BASE) + (LVL_W'(code) * LVL_W'(LVL_STEP));
      end
   endgenerate

   assign cancel_ext = DAC_W'(cancel);
   assign level_ext  = $signed(DAC_W'(level));
   assign dac        = cancel_ext + level_ext;

endmodule

// File: rtl/ocal_sequencer.sv
module ocal_sequencer
   import ocal_pkg::*;
#(
   parameter int SAMPLE_W   = 10,
   parameter int CODE_W     = 5,
   parameter int CANCEL_W   = 8,
   parameter int CAL_CYCLES = 40000,
   parameter int ZERO_LEVEL = 512,
   parameter int LVL_BASE   = 14,
   parameter int LVL_STEP   = 2,
   parameter bit COUNT_DOWN = 1'b0,
   localparam int LVL_MAX   = LVL_BASE + LVL_STEP * ((1 << CODE_W) - 1),
   localparam int LVL_W     = $clog2(LVL_MAX + 1),
   localparam int DAC_W     = ocal_max2(CANCEL_W, LVL_W + 1) + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reset_mode,
   input  logic [SAMPLE_W-1:0]     sample,
   input  logic [CODE_W-1:0]       clamp_code,
   output logic signed [DAC_W-1:0] dac_code,
   output logic                    busy,
   output logic                    done
);

   generate
      if (CAL_CYCLES < 2) begin : g_bad_cal
         $error("ocal_sequencer: CAL_CYCLES must be at least 2");
      end
      if (CANCEL_W < 2) begin : g_bad_cw
         $error("ocal_sequencer: CANCEL_W must be at least 2");
      end
      if ((ZERO_LEVEL < 0) || (ZERO_LEVEL >= (1 << SAMPLE_W))) begin : g_bad_zero
         $error("ocal_sequencer: ZERO_LEVEL outside sample range");
      end
      if ((LVL_BASE < 0) || (LVL_STEP < 1)) begin : g_bad_lvl
         $error("ocal_sequencer: clamp level parameters invalid");
      end
   endgenerate

   logic                       run_w;
   logic                       fin_w;
   logic signed [CANCEL_W-1:0] cancel_w;

   ocal_window_timer #(
      .CAL_CYCLES (CAL_CYCLES),
      .COUNT_DOWN (COUNT_DOWN)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (reset_mode),
      .run    (run_w),
      .finish (fin_w)
   );

   ocal_cancel_accum #(
      .SAMPLE_W   (SAMPLE_W),
      .CANCEL_W   (CANCEL_W),
      .ZERO_LEVEL (ZERO_LEVEL)
   ) u_accum (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (reset_mode),
      .step_en (run_w),
      .sample  (sample),
      .cancel  (cancel_w)
   );

   ocal_clamp_adder #(
      .CODE_W   (CODE_W),
      .LVL_BASE (LVL_BASE),
      .LVL_STEP (LVL_STEP),
      .LVL_W    (LVL_W),
      .CANCEL_W (CANCEL_W),
      .DAC_W    (DAC_W)
   ) u_adder (
      .cancel (cancel_w),
      .code   (clamp_code),
      .dac    (dac_code)
   );

   assign busy = run_w;
   assign done = fin_w;

endmodule

module ocal_sequencer_chk #(
   parameter int CAL_CYCLES = 40000,
   parameter int CANCEL_W   = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       reset_mode,
   input logic                       busy,
   input logic                       done,
   input logic signed [CANCEL_W-1:0] cancel
);

   localparam int RL_W = $clog2(CAL_CYCLES + 2);

   logic [RL_W-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len <= '0;
      end else if (!busy) begin
         run_len <= '0;
      end else begin
         run_len <= run_len + RL_W'(1);
      end
   end

   // R2: release of the hold bit starts the pass without any other input
   a_r2_auto_start: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reset_mode) && !reset_mode) |=> busy);

   // R3: the window never exceeds its length
   a_r3_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_len < RL_W'(CAL_CYCLES)));

   // R3: a completed window was exactly CAL_CYCLES long
   a_r3_window_len: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (run_len == RL_W'(CAL_CYCLES)));

   // R4: done is a single cycle
   a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4: done comes right after busy falls
   a_r4_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R5, R6: one LSB per step at most, no wrap
   a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !reset_mode) |=> ((cancel == $past(cancel)) ||
                                 (int'(cancel) == int'($past(cancel)) + 1) ||
                                 (int'(cancel) == int'($past(cancel)) - 1)));

   // R8: the hold bit aborts and clears
   a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
      reset_mode |=> (!busy && !done && (cancel == '0)));

   // R9: samples are ignored outside the window
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !reset_mode) |=> $stable(cancel));

endmodule

bind ocal_sequencer ocal_sequencer_chk #(
   .CAL_CYCLES (CAL_CYCLES),
   .CANCEL_W   (CANCEL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reset_mode (reset_mode),
   .busy       (busy),
   .done       (done),
   .cancel     (cancel_w)
);

// File: tb/ocal_sequencer_bench.sv
`timescale 1ns/1ps
module ocal_sequencer_bench;

   localparam int SW    = 10;
   localparam int CW    = 5;
   localparam int KW    = 5;
   localparam int CAL   = 20;
   localparam int ZERO  = 512;
   localparam int DW    = 9;
   localparam int C_MAX = 15;
   localparam int C_MIN = -16;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 reset_mode = 1'b1;
   logic [SW-1:0]        sample = SW'(ZERO);
   logic [KW-1:0]        clamp_code = 5'd9;
   logic signed [DW-1:0] dac_code;
   logic                 busy;
   logic                 done;

   int errors = 0;
   int checks = 0;
   int m_state = 0;
   int m_cnt = 0;
   int m_cancel = 0;
   bit m_done = 1'b0;
   int busy_seen = 0;
   int done_seen = 0;

   always #2.5 clk = ~clk;

   ocal_sequencer #(
      .SAMPLE_W   (SW),
      .CODE_W     (KW),
      .CANCEL_W   (CW),
      .CAL_CYCLES (CAL),
      .ZERO_LEVEL (ZERO)
   ) u_ocal_sequencer (
      .clk        (clk),
      .rst_n      (rst_n),
      .reset_mode (reset_mode),
      .sample     (sample),
      .clamp_code (clamp_code),
      .dac_code   (dac_code),
      .busy       (busy),
      .done       (done)
   );

   function automatic int lvl(input int c);
      return 14 + 2 * c;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick(input bit rm, input int smp, input int cc);
      reset_mode = rm;
      sample     = smp[SW-1:0];
      clamp_code = cc[KW-1:0];
      @(posedge clk);
      if (rm) begin
         m_state = 0; m_cnt = 0; m_cancel = 0; m_done = 1'b0;
      end else begin
         m_done = 1'b0;
         if (m_state == 0) begin
            m_state = 1; m_cnt = 0;
         end else if (m_state == 1) begin
            if (smp > ZERO && m_cancel > C_MIN) m_cancel--;
            else if (smp < ZERO && m_cancel < C_MAX) m_cancel++;
            if (m_cnt == CAL - 1) begin
               m_state = 2; m_done = 1'b1;
            end else begin
               m_cnt++;
            end
         end
      end
      @(negedge clk);
      if (busy) busy_seen++;
      if (done) done_seen++;
      check(busy == (m_state == 1), "R3 busy", int'(busy), int'(m_state == 1));
      check(done == m_done, "R4 done", int'(done), int'(m_done));
      check(int'(dac_code) == m_cancel + lvl(cc), "R5 dac", int'(dac_code), m_cancel + lvl(cc));
   endtask

   initial begin : watchdog
      #(200000 * 5);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      check(busy == 1'b0, "R1 busy", int'(busy), 0);
      check(done == 1'b0, "R1 done", int'(done), 0);
      check(int'(dac_code) == 32, "R1 dac", int'(dac_code), 32);
      rst_n = 1'b1;

      // R7: every clamp code while held
      for (int c = 0; c < 32; c++) begin
         tick(1'b1, ZERO, c);
         check(int'(dac_code) == lvl(c), "R7 level", int'(dac_code), lvl(c));
      end

      // R2, R3, R4, R6: run with samples above zero, saturating low
      busy_seen = 0; done_seen = 0;
      tick(1'b0, 600, 9);
      check(busy == 1'b1, "R2 start", int'(busy), 1);
      for (int i = 0; i < CAL + 5; i++) tick(1'b0, 600, 9);
      check(busy_seen == CAL, "R3 length", busy_seen, CAL);
      check(done_seen == 1, "R4 pulses", done_seen, 1);
      check(int'(dac_code) == 32 + C_MIN, "R6 low sat", int'(dac_code), 32 + C_MIN);

      // R9: samples after completion are ignored
      for (int i = 0; i < 12; i++) tick(1'b0, (i * 97) % 1024, 9);
      check(int'(dac_code) == 32 + C_MIN, "R9 idle", int'(dac_code), 32 + C_MIN);

      // R8, R6: abort clears, then run below zero, saturating high
      tick(1'b1, 0, 31);
      check(int'(dac_code) == 76, "R8 clear", int'(dac_code), 76);
      for (int i = 0; i < 4; i++) tick(1'b1, i * 200, 31);
      check(int'(dac_code) == 76, "R9 held", int'(dac_code), 76);
      for (int i = 0; i < CAL + 3; i++) tick(1'b0, 300, 31);
      check(int'(dac_code) == 76 + C_MAX, "R6 high sat", int'(dac_code), 76 + C_MAX);

      // R5, R7: mixed samples with clamp code changing every cycle
      tick(1'b1, ZERO, 0);
      for (int i = 0; i < CAL + 3; i++)
         tick(1'b0, ZERO + ((i % 3) - 1) * (i + 1), (i * 7) % 32);

      // R8: abort mid-window, then a full window after release
      tick(1'b1, ZERO, 4);
      for (int i = 0; i < 7; i++) tick(1'b0, 700, 4);
      tick(1'b1, 700, 4);
      check(busy == 1'b0, "R8 abort busy", int'(busy), 0);
      check(int'(dac_code) == lvl(4), "R8 abort dac", int'(dac_code), lvl(4));
      busy_seen = 0; done_seen = 0;
      for (int i = 0; i < CAL + 4; i++) tick(1'b0, 400, 4);
      check(busy_seen == CAL, "R8 restart length", busy_seen, CAL);

      // R4, R8: hold raised on the final window edge
      tick(1'b1, ZERO, 2);
      busy_seen = 0; done_seen = 0;
      tick(1'b0, 520, 2);
      for (int i = 0; i < CAL - 1; i++) tick(1'b0, 520, 2);
      tick(1'b1, 520, 2);
      for (int i = 0; i < 3; i++) tick(1'b1, 520, 2);
      check(done_seen == 0, "R4 no done on abort", done_seen, 0);
      check(int'(dac_code) == lvl(2), "R8 late abort dac", int'(dac_code), lvl(2));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule